// File: doc/BRIEF.md
# Snooping write-back coherence controller

This block keeps the coherence state of every line in one private write-back cache that shares a broadcast bus with other caches. The tag side is a small direct-mapped array. Each entry holds a tag and one of three states: invalid, shared (valid and clean), or dirty (modified, and the only current copy). The processor presents a line address and a read/write flag. The controller answers at once on a hit that needs no bus traffic. In every other case it wins the bus and issues exactly one transaction at a time, and the processor stalls until the controller acknowledges.

At the same time the controller watches the transactions that other caches put on the bus. A snooped read miss to a line held dirty makes this cache supply the line and fall back to shared. A snooped exclusive read or invalidate removes the local copy, and a dirty copy is written out first. A dirty line that must make room for a conflicting address is written back on the bus before the new miss goes out.

All addresses are line addresses. The low index bits select the entry and the remaining bits form the tag. Bus command codes are read = 0, exclusive read = 1, invalidate = 2, write-back = 3.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, and `bus_req`, `wb_valid` and `cpu_ack` are low. A read to an address that was dirty before reset issues a plain read (code 0) with no write-back.
- R2: A read that misses raises `bus_req` with code 0 and the requested address. `cpu_ack` is high in the cycle the grant arrives, and the line becomes shared.
- R3: A write that misses requests code 1 (exclusive read) for the address, and the line becomes dirty when granted.
- R4: A write that hits a shared line requests code 2 (invalidate). It is acknowledged only in the grant cycle, after which the line is dirty.
- R5: A read hit in any valid state, and a write hit on a dirty line, give `cpu_ack` in the same cycle as the request with no bus request.
- R6: A snooped read (code 0) whose address matches a dirty line gives `wb_valid` with that address in the next cycle, and leaves the line shared. A later local write then needs an invalidate.
- R7: A snooped exclusive read (code 1) or invalidate (code 2) that matches a valid line makes it invalid. If the line was dirty, `wb_valid` with the address follows in the next cycle.
- R8: A snoop that matches a shared line with code 0, a snoop whose tag differs from the stored tag, and a snooped write-back (code 3) leave the line unchanged and produce no `wb_valid`.
- R9: A miss that displaces a dirty line first requests code 3 with the victim address, and `wb_valid` carries that address in the cycle after its grant. The miss command follows. A shared victim is dropped without bus traffic.
- R10: While `bus_req` waits for `bus_gnt`, command and address stay fixed unless a snoop intervenes, `cpu_ack` stays low, and only one request is outstanding.
- R11: A snoop applies before a processor lookup made in the same cycle. An invalidating snoop that arrives while an invalidate waits for the bus turns the request into an exclusive read (code 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Requested line address |
| cpu_ack | output | 1 | Request completed this cycle |
| bus_req | output | 1 | Bus request for the pending transaction |
| bus_cmd | output | 2 | Pending command: 0 read, 1 exclusive read, 2 invalidate, 3 write-back |
| bus_addr | output | AW | Line address of the pending transaction |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| snoop_valid | input | 1 | Another cache's transaction is visible |
| snoop_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snoop_addr | input | AW | Snooped line address |
| wb_valid | output | 1 | Dirty line data is being supplied or written back |
| wb_addr | output | AW | Line address of that data |

## Verification
The critical overlap is a snoop and the processor side acting on the same line in one cycle. The bench forces it in two ways. It presents a snooped exclusive read in the same cycle as a local read of a dirty line, and expects a miss, a plain read request and a write-back instead of a hit. It also injects an invalidate while an upgrade waits for the bus, and expects the pending command to change to exclusive read before the grant. After the grant, a snooped read must find the line dirty.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_DRT = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_INV = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;

  // state a valid, tag-matching line moves to when another cache's command is seen
  function automatic line_st_e snoop_next(line_st_e cur, bus_cmd_e cmd);
    case (cmd)
      BC_RD:          return (cur == LN_DRT) ? LN_SHR : cur;
      BC_RDX, BC_INV: return LN_INV;
      default:        return cur;
    endcase
  endfunction

  // dirty data must leave this cache for any command other than a write-back
  function automatic logic snoop_needs_wb(line_st_e cur, bus_cmd_e cmd);
    return (cur == LN_DRT) && (cmd != BC_WB);
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NL = 8,
  parameter int IW = 3,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx_a,
  output line_st_e      st_a,
  output logic [TW-1:0] tg_a,
  input  logic [IW-1:0] rd_idx_b,
  output line_st_e      st_b,
  output logic [TW-1:0] tg_b,
  input  logic          s_we,
  input  logic [IW-1:0] s_idx,
  input  line_st_e      s_st,
  input  logic          c_we,
  input  logic [IW-1:0] c_idx,
  input  line_st_e      c_st,
  input  logic [TW-1:0] c_tg
);

  line_st_e      st_q [NL];
  logic [TW-1:0] tg_q [NL];

  for (genvar i = 0; i < NL; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= LN_INV;
        tg_q[i] <= '0;
      end else if (c_we && c_idx == IW'(i)) begin
        st_q[i] <= c_st;
        tg_q[i] <= c_tg;
      end else if (s_we && s_idx == IW'(i)) begin
        st_q[i] <= s_st;
      end
    end
  end

  assign st_a = st_q[rd_idx_a];
  assign tg_a = tg_q[rd_idx_a];
  assign st_b = st_q[rd_idx_b];
  assign tg_b = tg_q[rd_idx_b];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 3,
  parameter int TW = AW - IW
) (
  input  logic          snoop_valid,
  input  logic [1:0]    snoop_cmd,
  input  logic [AW-1:0] snoop_addr,
  input  line_st_e      line_st,
  input  logic [TW-1:0] line_tag,
  output logic          snp_upd,
  output line_st_e      snp_st,
  output logic          snp_wb
);

  bus_cmd_e cmd;
  logic     hit;

  assign cmd     = bus_cmd_e'(snoop_cmd);
  assign hit     = snoop_valid && (line_st != LN_INV) && (line_tag == snoop_addr[AW-1:IW]);
  assign snp_st  = snoop_next(line_st, cmd);
  assign snp_upd = hit && (snp_st != line_st);
  assign snp_wb  = hit && snoop_needs_wb(line_st, cmd);

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NLINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ack,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          snoop_valid,
  input  logic [1:0]    snoop_cmd,
  input  logic [AW-1:0] snoop_addr,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr
);

  localparam int IW = $clog2(NLINES);
  localparam int TW = AW - IW;

  logic          in_bus_q;
  bus_cmd_e      pend_q, pend_d, miss_q, miss_d;
  logic [AW-1:0] paddr_q, paddr_d, vict_q, vict_d;
  logic          go_bus, leave_bus;

  logic [IW-1:0] cpu_idx, rd_idx, snp_idx;
  logic [TW-1:0] cpu_tag;
  line_st_e      st_a, st_b, eff_st, snp_st, c_st;
  logic [TW-1:0] tg_a, tg_b, c_tg;
  logic          snp_upd, snp_wb, evict_wb, cpu_hit, c_we;

  assign cpu_idx = cpu_addr[IW-1:0];
  assign cpu_tag = cpu_addr[AW-1:IW];
  assign snp_idx = snoop_addr[IW-1:0];
  assign rd_idx  = in_bus_q ? paddr_q[IW-1:0] : cpu_idx;

  coh_line_store #(.NL(NLINES), .IW(IW), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx_a(rd_idx), .st_a(st_a), .tg_a(tg_a),
    .rd_idx_b(snp_idx), .st_b(st_b), .tg_b(tg_b),
    .s_we(snp_upd), .s_idx(snp_idx), .s_st(snp_st),
    .c_we(c_we), .c_idx(paddr_q[IW-1:0]), .c_st(c_st), .c_tg(c_tg)
  );

  coh_snoop_unit #(.AW(AW), .IW(IW), .TW(TW)) u_snoop (
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .line_st(st_b), .line_tag(tg_b),
    .snp_upd(snp_upd), .snp_st(snp_st), .snp_wb(snp_wb)
  );

  // the snoop is ordered first: the lookup sees the state it leaves behind
  assign eff_st  = (snp_upd && snp_idx == rd_idx) ? snp_st : st_a;
  assign cpu_hit = (eff_st != LN_INV) && (tg_a == cpu_tag);

  always_comb begin
    cpu_ack   = 1'b0;
    go_bus    = 1'b0;
    leave_bus = 1'b0;
    evict_wb  = 1'b0;
    c_we      = 1'b0;
    c_st      = LN_INV;
    c_tg      = paddr_q[AW-1:IW];
    pend_d    = pend_q;
    miss_d    = miss_q;
    paddr_d   = paddr_q;
    vict_d    = vict_q;
    if (!in_bus_q) begin
      if (cpu_req) begin
        if (cpu_hit && (!cpu_we || eff_st == LN_DRT)) begin
          cpu_ack = 1'b1;
        end else begin
          go_bus  = 1'b1;
          paddr_d = cpu_addr;
          if (cpu_hit) begin
            pend_d = BC_INV;
          end else if (eff_st == LN_DRT) begin
            pend_d = BC_WB;
            miss_d = cpu_we ? BC_RDX : BC_RD;
            vict_d = {tg_a, cpu_idx};
          end else begin
            pend_d = cpu_we ? BC_RDX : BC_RD;
          end
        end
      end
    end else if (bus_gnt) begin
      c_we = 1'b1;
      case (pend_q)
        BC_WB: begin
          c_st     = LN_INV;
          c_tg     = tg_a;
          evict_wb = 1'b1;
          pend_d   = miss_q;
        end
        BC_RD: begin
          c_st      = LN_SHR;
          cpu_ack   = 1'b1;
          leave_bus = 1'b1;
        end
        default: begin
          c_st      = LN_DRT;
          cpu_ack   = 1'b1;
          leave_bus = 1'b1;
        end
      endcase
    end else begin
      if (pend_q == BC_INV && eff_st == LN_INV) pend_d = BC_RDX;
      if (pend_q == BC_WB && eff_st != LN_DRT)  pend_d = miss_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_bus_q <= 1'b0;
      pend_q   <= BC_RD;
      miss_q   <= BC_RD;
      paddr_q  <= '0;
      vict_q   <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
    end else begin
      if (go_bus)         in_bus_q <= 1'b1;
      else if (leave_bus) in_bus_q <= 1'b0;
      pend_q   <= pend_d;
      miss_q   <= miss_d;
      paddr_q  <= paddr_d;
      vict_q   <= vict_d;
      wb_valid <= snp_wb || evict_wb;
      if (snp_wb)        wb_addr <= snoop_addr;
      else if (evict_wb) wb_addr <= vict_q;
    end
  end

  assign bus_req  = in_bus_q;
  assign bus_cmd  = pend_q;
  assign bus_addr = (pend_q == BC_WB) ? vict_q : paddr_q;

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ack,
  input logic          bus_req,
  input logic [1:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic          bus_gnt,
  input logic          snoop_valid,
  input logic [AW-1:0] snoop_addr,
  input logic          wb_valid,
  input logic [AW-1:0] wb_addr,
  input logic          snp_wb
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snoop_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R10
  no_early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !cpu_ack);

  // R9
  evict_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd3) |=> (wb_valid && wb_addr == $past(bus_addr)));

  // R6
  snoop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |=> (wb_valid && wb_addr == $past(snoop_addr)));

  // R4
  inv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd2) |-> cpu_ack);

  // R5
  hit_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !bus_req) |=> !bus_req);

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .bus_req(bus_req),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
  .wb_valid(wb_valid), .wb_addr(wb_addr), .snp_wb(snp_wb)
);

// File: tb/tb_coh_snoop_ctrl.sv
module tb_coh_snoop_ctrl;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ack, bus_req, bus_gnt = 1'b0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          snoop_valid = 1'b0;
  logic [1:0]    snoop_cmd = 2'd0;
  logic [AW-1:0] snoop_addr = '0;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  coh_snoop_ctrl #(.AW(AW), .NLINES(8)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
    .snoop_addr(snoop_addr), .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one processor request; grants every bus request after one idle wait cycle
  task automatic do_cpu(input logic we, input logic [AW-1:0] a, output int n,
                        output logic [1:0] c0, output logic [AW-1:0] a0, output logic [1:0] c1);
    logic [1:0]    cm;
    logic [AW-1:0] ad;
    logic          ackg;
    bit            done = 0;
    n = 0; c0 = 0; a0 = 0; c1 = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    for (int g = 0; g < 12 && !done; g++) begin
      #1;
      if (cpu_ack && !bus_req) begin
        cpu_req = 1'b0; done = 1;
      end else if (bus_req) begin
        cm = bus_cmd; ad = bus_addr;
        if (n == 0) begin c0 = cm; a0 = ad; end else c1 = cm;
        n++;
        @(negedge clk); #1;
        chk(bus_req && bus_cmd == cm && bus_addr == ad && !cpu_ack, "R10", "wait hold", bus_cmd, cm);
        bus_gnt = 1'b1; #0.5;
        ackg = cpu_ack;
        @(negedge clk);
        bus_gnt = 1'b0;
        if (cm == 2'd3) begin
          #1;
          chk(wb_valid && wb_addr == ad && !ackg, "R9", "evict wb", wb_addr, ad);
          @(negedge clk);
        end else begin
          chk(ackg, "R2", "ack on grant", ackg, 1);
          cpu_req = 1'b0; done = 1;
        end
      end else begin
        @(negedge clk);
      end
    end
    if (!done) begin
      cpu_req = 1'b0;
      chk(0, "R10", "request never completed", 0, 1);
    end
  endtask

  task automatic do_snoop(input logic [1:0] cm, input logic [AW-1:0] a,
                          output logic wv, output logic [AW-1:0] wa);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = cm; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    wv = wb_valid; wa = wb_addr;
  endtask

  typedef struct packed {
    logic [1:0]    kind;   // 0 read, 1 write, 2 snoop
    logic [1:0]    scmd;
    logic [AW-1:0] addr;
    logic [1:0]    n;      // bus transactions expected
    logic [1:0]    c0;
    logic [AW-1:0] a0;
    logic [1:0]    c1;
    logic          wb;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 8'h11, 2'd1, 2'd0, 8'h11, 2'd0, 1'b0, 4'd2},  // R2 read miss
    '{2'd0, 2'd0, 8'h11, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd5},  // R5 read hit
    '{2'd1, 2'd0, 8'h11, 2'd1, 2'd2, 8'h11, 2'd0, 1'b0, 4'd4},  // R4 upgrade
    '{2'd1, 2'd0, 8'h11, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd5},  // R5 write hit dirty
    '{2'd2, 2'd0, 8'h11, 2'd0, 2'd0, 8'h00, 2'd0, 1'b1, 4'd6},  // R6 supply
    '{2'd1, 2'd0, 8'h11, 2'd1, 2'd2, 8'h11, 2'd0, 1'b0, 4'd6},  // R6 now shared
    '{2'd2, 2'd2, 8'h11, 2'd0, 2'd0, 8'h00, 2'd0, 1'b1, 4'd7},  // R7 inv dirty
    '{2'd0, 2'd0, 8'h11, 2'd1, 2'd0, 8'h11, 2'd0, 1'b0, 4'd7},  // R7 gone
    '{2'd2, 2'd0, 8'h11, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd8},  // R8 read on shared
    '{2'd2, 2'd1, 8'h11, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd7},  // R7 rdx on shared
    '{2'd0, 2'd0, 8'h11, 2'd1, 2'd0, 8'h11, 2'd0, 1'b0, 4'd7},  // R7 gone
    '{2'd1, 2'd0, 8'h22, 2'd1, 2'd1, 8'h22, 2'd0, 1'b0, 4'd3},  // R3 write miss
    '{2'd2, 2'd1, 8'h2A, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd8},  // R8 tag differs
    '{2'd2, 2'd3, 8'h22, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd8},  // R8 write-back ignored
    '{2'd1, 2'd0, 8'h22, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, 4'd3},  // R3 still dirty
    '{2'd0, 2'd0, 8'h2A, 2'd2, 2'd3, 8'h22, 2'd0, 1'b0, 4'd9},  // R9 dirty victim
    '{2'd0, 2'd0, 8'h33, 2'd1, 2'd0, 8'h33, 2'd0, 1'b0, 4'd2},  // R2 read miss
    '{2'd1, 2'd0, 8'h3B, 2'd1, 2'd1, 8'h3B, 2'd0, 1'b0, 4'd9}   // R9 shared victim silent
  };

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int            n;
    logic [1:0]    c0, c1;
    logic [AW-1:0] a0, wa;
    logic          wv;
    string         tag;

    repeat (3) @(negedge clk);
    #1;
    // R1 outputs quiet in reset and just after release
    chk(!bus_req && !wb_valid && !cpu_ack, "R1", "reset outputs", {bus_req, wb_valid, cpu_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!bus_req && !wb_valid && !cpu_ack, "R1", "after release", {bus_req, wb_valid, cpu_ack}, 0);

    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d", VECS[v].rq);
      if (VECS[v].kind == 2'd2) begin
        do_snoop(VECS[v].scmd, VECS[v].addr, wv, wa);
        chk(wv == VECS[v].wb, tag, $sformatf("vec%0d wb_valid", v), wv, VECS[v].wb);
        if (VECS[v].wb) chk(wa == VECS[v].addr, tag, $sformatf("vec%0d wb_addr", v), wa, VECS[v].addr);
      end else begin
        do_cpu(VECS[v].kind[0], VECS[v].addr, n, c0, a0, c1);
        chk(n == int'(VECS[v].n), tag, $sformatf("vec%0d bus count", v), n, VECS[v].n);
        if (VECS[v].n != 0)
          chk(c0 == VECS[v].c0 && a0 == VECS[v].a0, tag, $sformatf("vec%0d first cmd/addr", v),
              {c0, a0}, {VECS[v].c0, VECS[v].a0});
        if (VECS[v].n == 2)
          chk(c1 == VECS[v].c1, tag, $sformatf("vec%0d second cmd", v), c1, VECS[v].c1);
      end
    end

    // R11 invalidate arrives while the upgrade waits: pending becomes exclusive read
    do_cpu(1'b0, 8'h44, n, c0, a0, c1);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h44;
    @(negedge clk); #1;
    chk(bus_req && bus_cmd == 2'd2 && bus_addr == 8'h44, "R4", "upgrade pending", bus_cmd, 2);
    snoop_valid = 1'b1; snoop_cmd = 2'd2; snoop_addr = 8'h44;
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk(bus_req && bus_cmd == 2'd1 && !cpu_ack, "R11", "upgrade turned exclusive", bus_cmd, 1);
    bus_gnt = 1'b1; #0.5;
    chk(cpu_ack, "R11", "ack on grant", cpu_ack, 1);
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0;
    do_snoop(2'd0, 8'h44, wv, wa);
    chk(wv && wa == 8'h44, "R11", "line dirty after converted fill", wv, 1);

    // R11 snoop and lookup on the same dirty line in one cycle
    do_cpu(1'b1, 8'h55, n, c0, a0, c1);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h55;
    snoop_valid = 1'b1; snoop_cmd = 2'd1; snoop_addr = 8'h55;
    #1;
    chk(!cpu_ack, "R11", "no hit under same-cycle snoop", cpu_ack, 0);
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk(bus_req && bus_cmd == 2'd0 && bus_addr == 8'h55, "R11", "miss issued", bus_cmd, 0);
    chk(wb_valid && wb_addr == 8'h55, "R7", "dirty supplied", wb_addr, 8'h55);
    bus_gnt = 1'b1; #0.5;
    chk(cpu_ack, "R2", "ack on grant", cpu_ack, 1);
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0;

    // R1 reset clears dirty state: no write-back for the old dirty line
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_cpu(1'b0, 8'h3B, n, c0, a0, c1);
    chk(n == 1 && c0 == 2'd0 && a0 == 8'h3B, "R1", "read after reset", {c0, a0}, {2'd0, 8'h3B});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule